// File: doc/BRIEF.md
# Dual A/D converter register and status bank

This block is the register front end for two identical eight-channel analog-to-digital converter cores. Each core appears as a simple handshake: a one-cycle `cv_done` pulse, with the channel number and a 10-bit result alongside it. The bank stores the latest result for each channel and the latest result from any channel. It keeps a done flag and an overrun flag for each channel, and it raises one interrupt line per converter from the done flags that software has enabled.

Software reaches the bank through a single register bus. The top address bit picks the converter, and the low six bits pick the register inside that converter's window. A conversion is requested by writing the start bit of the control register. A conversion can also be requested by writing the shared start location, which exists only in converter 0's window and starts every converter whose mode has been set, in the same cycle. The bank does not sequence conversions itself. It only forwards one-cycle start pulses to the cores.

Top module: `adc_pair_regs`

## Requirements
- R1: After reset, each converter reads control = 0x0000_0001, status = 0, interrupt enable = 0x0000_0100 and all data registers = 0. Both `irq` lines and both `cv_start` lines are low.
- R2: Registers per converter window, at byte offset: control 0x00 (bits [23:0] read/write), latest-any data 0x04, shared start 0x08, interrupt enable 0x0C (bits [8:0] read/write), channel k data at 0x10+4k, status 0x30. Bits not listed read as zero. Read data is returned in the cycle after the read.
- R3: A control write with bit 24 set gives a one-cycle `cv_start` pulse for that converter in the cycle after the write. Bit 24 reads back as zero.
- R4: A write to offset 0x08 in converter 0's window pulses `cv_start` in the cycle after the write, at the same time, for every converter whose control register has been written since reset. Converters not yet written get no pulse. Offset 0x08 in converter 1's window starts nothing.
- R5: On `cv_done`, the result goes to bits [15:6] of that channel's data register and of the latest-any data register. Bit 31 (done) is set in both registers.
- R6: A result arriving while its channel's done flag is still set sets that channel's overrun flag (bit 30). Reading a channel data register clears that channel's done and overrun flags.
- R7: Reading the latest-any data register clears its done bit 31 and its overrun bit 30.
- R8: The status register holds the channel done flags in bits [7:0], the channel overrun flags in bits [15:8], and the pending interrupt condition in bit 16. Writes to it have no effect.
- R9: `irq` is the OR of (channel done AND enable bit k) over the channels, ORed with (latest-any done AND enable bit 8). It is registered, so it follows a flag change one cycle later.
- R10: A read of offset 0x08 returns zero. A write to a channel data register or to the latest-any data register changes nothing.
- R11: When a new result for a channel arrives in the same cycle as a read of that channel, the new result is kept with done set. The read returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | [6] converter select, [5:0] byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| cv_done | input | 2 | Per converter: result valid this cycle |
| cv_chan | input | 6 | Per converter channel number, 3 bits each |
| cv_res | input | 20 | Per converter result, 10 bits each |
| cv_start | output | 2 | Per converter start pulse |
| irq | output | 2 | Per converter interrupt |

## Verification
The assertions assume that every bus access lasts exactly one cycle, with `bus_en` low while reset is held. They also assume that `cv_done` happens only as single-cycle events. Under those assumptions, any start pulse, any rise of an interrupt line and any fall of an interrupt line can be traced to a bus access or to a converter event one or two cycles earlier. The bench drives all inputs on the falling clock edge, as one-cycle strobes. Random traffic spreads over every offset, including the reserved offset 0x34, and conversion results arrive at random, so flag set and flag clear often fall in the same cycle.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  // byte offsets inside one converter window
  localparam int OFS_CTL    = 'h00;
  localparam int OFS_GDATA  = 'h04;
  localparam int OFS_GSTART = 'h08;
  localparam int OFS_INTEN  = 'h0C;
  localparam int OFS_CH0    = 'h10;
  localparam int OFS_STAT   = 'h30;
  // data word layout
  localparam int DONE_BIT   = 31;
  localparam int OVR_BIT    = 30;
  localparam int RES_LSB    = 6;
  // control word layout
  localparam int CTL_MODE_W = 24;
  localparam int CTL_GO_BIT = 24;
endpackage

// File: rtl/adcr_chan_bank.sv
module adcr_chan_bank #(
  parameter int N_CH  = 8,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cv_done,
  input  logic [CH_W-1:0]  cv_chan,
  input  logic [RES_W-1:0] cv_res,
  input  logic             rd_clr,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [N_CH-1:0]  done_flags,
  output logic [N_CH-1:0]  ovr_flags,
  output logic [RES_W-1:0] rd_res
);
  logic [RES_W-1:0] res_q [N_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) res_q[i] <= '0;
    end else if (cv_done) begin
      res_q[cv_chan] <= cv_res;
    end
  end

  assign rd_res = res_q[rd_ch];

  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    logic hit, clr;
    assign hit = cv_done && (cv_chan == CH_W'(i));
    assign clr = rd_clr && (rd_ch == CH_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        done_flags[i] <= 1'b0;
        ovr_flags[i]  <= 1'b0;
      end else if (hit) begin
        // a new result wins over a same-cycle read
        ovr_flags[i]  <= ovr_flags[i] | done_flags[i];
        done_flags[i] <= 1'b1;
      end else if (clr) begin
        done_flags[i] <= 1'b0;
        ovr_flags[i]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adcr_unit.sv
module adcr_unit
  import adcr_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(N_CH),
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_en,
  input  logic             req_wr,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [31:0]      req_wdata,
  input  logic             gstart,
  input  logic             cv_done,
  input  logic [CH_W-1:0]  cv_chan,
  input  logic [RES_W-1:0] cv_res,
  output logic             start_o,
  output logic             irq_o,
  output logic [31:0]      rd_word
);
  localparam int IE_W    = N_CH + 1;
  localparam int WORD_W  = OFS_W - 2;
  localparam int CH_BASE = OFS_CH0 / 4;

  logic [CTL_MODE_W-1:0] ctl_q;
  logic                  armed_q;
  logic [IE_W-1:0]       ie_q;
  logic [RES_W-1:0]      gres_q;
  logic                  gdone_q, govr_q;
  logic [N_CH-1:0]       done_f, ovr_f;
  logic [RES_W-1:0]      ch_res;
  logic                  pending;

  logic [WORD_W-1:0] word_idx;
  logic              is_ch, rd_req, wr_ctl, wr_ie, rd_gdata;
  logic [CH_W-1:0]   ch_idx;
  logic [31:0]       unused_wdata;

  assign word_idx  = req_ofs[OFS_W-1:2];
  assign is_ch     = (int'(word_idx) >= CH_BASE) && (int'(word_idx) < CH_BASE + N_CH);
  assign ch_idx    = CH_W'(word_idx - WORD_W'(CH_BASE));
  assign rd_req    = req_en && !req_wr;
  assign wr_ctl    = req_en && req_wr && (req_ofs == OFS_W'(OFS_CTL));
  assign wr_ie     = req_en && req_wr && (req_ofs == OFS_W'(OFS_INTEN));
  assign rd_gdata  = rd_req && (req_ofs == OFS_W'(OFS_GDATA));
  assign unused_wdata = req_wdata;

  adcr_chan_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst(rst), .cv_done(cv_done), .cv_chan(cv_chan), .cv_res(cv_res),
    .rd_clr(rd_req && is_ch), .rd_ch(ch_idx),
    .done_flags(done_f), .ovr_flags(ovr_f), .rd_res(ch_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_MODE_W'(1);
      armed_q <= 1'b0;
      ie_q    <= IE_W'(1) << N_CH;
      start_o <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_q   <= req_wdata[CTL_MODE_W-1:0];
        armed_q <= 1'b1;
      end
      if (wr_ie) ie_q <= req_wdata[IE_W-1:0];
      start_o <= (wr_ctl && req_wdata[CTL_GO_BIT]) || (gstart && armed_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gres_q  <= '0;
      gdone_q <= 1'b0;
      govr_q  <= 1'b0;
    end else if (cv_done) begin
      gres_q  <= cv_res;
      govr_q  <= govr_q | gdone_q;
      gdone_q <= 1'b1;
    end else if (rd_gdata) begin
      gdone_q <= 1'b0;
      govr_q  <= 1'b0;
    end
  end

  assign pending = |(done_f & ie_q[N_CH-1:0]) || (gdone_q && ie_q[N_CH]);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending;
  end

  always_comb begin
    rd_word = '0;
    if (is_ch) begin
      rd_word[DONE_BIT]            = done_f[ch_idx];
      rd_word[OVR_BIT]             = ovr_f[ch_idx];
      rd_word[RES_LSB +: RES_W]    = ch_res;
    end else if (req_ofs == OFS_W'(OFS_CTL)) begin
      rd_word[CTL_MODE_W-1:0]      = ctl_q;
    end else if (req_ofs == OFS_W'(OFS_GDATA)) begin
      rd_word[DONE_BIT]            = gdone_q;
      rd_word[OVR_BIT]             = govr_q;
      rd_word[RES_LSB +: RES_W]    = gres_q;
    end else if (req_ofs == OFS_W'(OFS_INTEN)) begin
      rd_word[IE_W-1:0]            = ie_q;
    end else if (req_ofs == OFS_W'(OFS_STAT)) begin
      rd_word[N_CH-1:0]            = done_f;
      rd_word[N_CH +: N_CH]        = ovr_f;
      rd_word[2*N_CH]              = pending;
    end
  end
endmodule

// File: rtl/adc_pair_regs.sv
module adc_pair_regs
  import adcr_pkg::*;
#(
  parameter int N_ADC  = 2,
  parameter int N_CH   = 8,
  parameter int RES_W  = 10,
  parameter int OFS_W  = 6,
  parameter int CH_W   = $clog2(N_CH),
  parameter int SEL_W  = (N_ADC > 1) ? $clog2(N_ADC) : 1,
  parameter int ADDR_W = OFS_W + SEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_en,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [N_ADC-1:0]       cv_done,
  input  logic [N_ADC*CH_W-1:0]  cv_chan,
  input  logic [N_ADC*RES_W-1:0] cv_res,
  output logic [N_ADC-1:0]       cv_start,
  output logic [N_ADC-1:0]       irq
);
  logic [SEL_W-1:0] sel;
  logic [OFS_W-1:0] ofs;
  logic             gstart;
  logic [31:0]      unit_word [N_ADC];

  assign sel    = bus_addr[ADDR_W-1:OFS_W];
  assign ofs    = bus_addr[OFS_W-1:0];
  assign gstart = bus_en && bus_wr && (sel == '0) && (ofs == OFS_W'(OFS_GSTART));

  for (genvar u = 0; u < N_ADC; u++) begin : g_unit
    adcr_unit #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W), .OFS_W(OFS_W)) u_unit (
      .clk(clk), .rst(rst),
      .req_en(bus_en && (sel == SEL_W'(u))), .req_wr(bus_wr),
      .req_ofs(ofs), .req_wdata(bus_wdata), .gstart(gstart),
      .cv_done(cv_done[u]), .cv_chan(cv_chan[u*CH_W +: CH_W]),
      .cv_res(cv_res[u*RES_W +: RES_W]),
      .start_o(cv_start[u]), .irq_o(irq[u]), .rd_word(unit_word[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_wr) begin
      bus_rdata <= (int'(sel) < N_ADC) ? unit_word[sel] : '0;
    end
  end
endmodule

// File: rtl/adc_pair_chk.sv
module adc_pair_chk #(
  parameter int N_ADC  = 2,
  parameter int OFS_W  = 6,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [N_ADC-1:0]  cv_done,
  input logic [N_ADC-1:0]  cv_start,
  input logic [N_ADC-1:0]  irq
);
  // R1: outputs quiet right after a reset cycle
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (irq == '0 && cv_start == '0));

  // R3 / R4: any start pulse is caused by a write one cycle earlier
  a_r3_start_after_write: assert property (@(posedge clk) disable iff (rst)
    (|cv_start) |-> $past(bus_en && bus_wr));

  // R10: the shared start location reads as zero
  a_r10_gstart_reads_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_en && !bus_wr && bus_addr[OFS_W-1:0] == OFS_W'(8)) |-> bus_rdata == '0);

  for (genvar u = 0; u < N_ADC; u++) begin : g_irq
    // R9: interrupt rises only after a result or an enable write
    a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[u]) |-> ($past(cv_done[u], 2) || $past(bus_en && bus_wr, 2)));
    // R6 / R7: interrupt falls only after a bus access
    a_r6_irq_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(irq[u]) |-> $past(bus_en, 2));
  end
endmodule

bind adc_pair_regs adc_pair_chk #(.N_ADC(N_ADC), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .cv_done(cv_done), .cv_start(cv_start), .irq(irq)
);

// File: tb/sim_adc_pair_regs.sv
module sim_adc_pair_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cv_done = '0;
  logic [5:0]  cv_chan = '0;
  logic [19:0] cv_res = '0;
  logic [1:0]  cv_start, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_pair_regs u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cv_done(cv_done), .cv_chan(cv_chan),
    .cv_res(cv_res), .cv_start(cv_start), .irq(irq)
  );

  // reference model state
  logic [23:0] m_ctl [2];
  bit          m_armed [2];
  logic [8:0]  m_ie [2];
  logic [9:0]  m_res [2][8];
  logic [7:0]  m_done [2], m_ovr [2];
  logic [9:0]  m_gres [2];
  bit          m_gdone [2], m_govr [2];

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_ctl[u] = 24'd1; m_armed[u] = 0; m_ie[u] = 9'h100;
      m_done[u] = '0; m_ovr[u] = '0; m_gres[u] = '0; m_gdone[u] = 0; m_govr[u] = 0;
      for (int c = 0; c < 8; c++) m_res[u][c] = '0;
    end
  endtask

  function automatic bit pend(int u);
    return (|(m_done[u] & m_ie[u][7:0])) || (m_gdone[u] && m_ie[u][8]);
  endfunction

  function automatic logic [31:0] exp_word(int u, logic [5:0] ofs);
    logic [31:0] w = '0;
    int wi = int'(ofs[5:2]);
    if (wi >= 4 && wi < 12) begin
      w[31] = m_done[u][wi-4]; w[30] = m_ovr[u][wi-4]; w[15:6] = m_res[u][wi-4];
    end else if (ofs == 6'h00) w[23:0] = m_ctl[u];
    else if (ofs == 6'h04) begin w[31] = m_gdone[u]; w[30] = m_govr[u]; w[15:6] = m_gres[u]; end
    else if (ofs == 6'h0C) w[8:0] = m_ie[u];
    else if (ofs == 6'h30) begin w[7:0] = m_done[u]; w[15:8] = m_ovr[u]; w[16] = pend(u); end
    return w;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // one bus/converter cycle, checked against the model
  task automatic tick(input bit en, input bit wr, input logic [6:0] addr, input logic [31:0] wd,
                      input logic [1:0] dn, input logic [5:0] ch, input logic [19:0] rs,
                      input string req);
    logic [1:0]  e_start, e_irq;
    logic [31:0] e_rd;
    int sel;
    logic [5:0] ofs;
    bit gst, rd;
    @(negedge clk);
    bus_en = en; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    cv_done = dn; cv_chan = ch; cv_res = rs;
    sel = int'(addr[6]); ofs = addr[5:0];
    gst = en && wr && sel == 0 && ofs == 6'h08;
    rd = en && !wr;
    for (int u = 0; u < 2; u++) begin
      e_start[u] = (en && wr && sel == u && ofs == 6'h00 && wd[24]) || (gst && m_armed[u]);
      e_irq[u] = pend(u);
    end
    e_rd = exp_word(sel, ofs);
    @(posedge clk); #1;
    check(gst ? "R4" : "R3", "cv_start", 32'(cv_start), 32'(e_start));
    check("R9", "irq", 32'(irq), 32'(e_irq));
    if (rd) check(req, "rdata", bus_rdata, e_rd);
    // model update
    for (int u = 0; u < 2; u++) begin
      int wi = int'(ofs[5:2]);
      bit mine = en && sel == u;
      bit chrd = mine && !wr && wi >= 4 && wi < 12;
      if (mine && wr && ofs == 6'h00) begin m_ctl[u] = wd[23:0]; m_armed[u] = 1; end
      if (mine && wr && ofs == 6'h0C) m_ie[u] = wd[8:0];
      for (int c = 0; c < 8; c++) begin
        if (dn[u] && int'(ch[u*3 +: 3]) == c) begin
          m_ovr[u][c] = m_ovr[u][c] | m_done[u][c]; m_done[u][c] = 1'b1;
          m_res[u][c] = rs[u*10 +: 10];
        end else if (chrd && wi - 4 == c) begin
          m_done[u][c] = 1'b0; m_ovr[u][c] = 1'b0;
        end
      end
      if (dn[u]) begin
        m_govr[u] = m_govr[u] | m_gdone[u]; m_gdone[u] = 1; m_gres[u] = rs[u*10 +: 10];
      end else if (mine && !wr && ofs == 6'h04) begin
        m_gdone[u] = 0; m_govr[u] = 0;
      end
    end
    bus_en = 1'b0; cv_done = '0;
  endtask

  function automatic logic [6:0] A(int u, int ofs);
    return {u[0], ofs[5:0]};
  endfunction

  task automatic rd(int u, int ofs, string req);
    tick(1, 0, A(u, ofs), '0, 2'b00, '0, '0, req);
  endtask
  task automatic wr(int u, int ofs, logic [31:0] d, string req);
    tick(1, 1, A(u, ofs), d, 2'b00, '0, '0, req);
  endtask
  task automatic conv(int u, int c, logic [9:0] r, string req);
    logic [5:0]  ch = '0;
    logic [19:0] rs = '0;
    ch[u*3 +: 3] = 3'(c); rs[u*10 +: 10] = r;
    tick(0, 0, '0, '0, 2'(1 << u), ch, rs, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    check("R1", "irq at reset", 32'(irq), 0);
    check("R1", "start at reset", 32'(cv_start), 0);
    rd(0, 'h00, "R1"); rd(1, 'h0C, "R1"); rd(0, 'h30, "R1"); rd(1, 'h04, "R1"); rd(0, 'h1C, "R1");
    // R4 shared start ignored before any control write
    wr(0, 'h08, 32'hFFFF_FFFF, "R4");
    // R3 start through control of converter 1
    wr(1, 'h00, 32'h0100_0005, "R3");
    rd(1, 'h00, "R3");
    rd(1, 'h00, "R2");
    // R4 only converter 1 armed, then both
    wr(0, 'h08, 32'h0, "R4");
    wr(0, 'h00, 32'h0000_0002, "R4");
    wr(0, 'h08, 32'h0, "R4");
    wr(1, 'h08, 32'h0, "R4");
    // R10 start location reads zero
    rd(0, 'h08, "R10");
    // R5 capture, R7 global clear
    conv(0, 3, 10'h2AB, "R5");
    rd(0, 'h1C, "R5");
    rd(0, 'h04, "R5");
    rd(0, 'h04, "R7");
    // R6 overrun then clear
    conv(0, 5, 10'h011, "R6");
    conv(0, 5, 10'h3FF, "R6");
    rd(0, 'h30, "R6");
    rd(0, 'h24, "R6");
    rd(0, 'h24, "R6");
    rd(0, 'h04, "R7");
    // R8 status write ignored, R10 data writes ignored
    conv(0, 1, 10'h155, "R8");
    wr(0, 'h30, 32'hFFFF_FFFF, "R8");
    rd(0, 'h30, "R8");
    wr(0, 'h14, 32'h0000_0000, "R10");
    wr(0, 'h04, 32'h0000_0000, "R10");
    rd(0, 'h14, "R10");
    rd(0, 'h04, "R10");
    // R9 per-channel enable selects the interrupt source
    wr(1, 'h0C, 32'h0000_0004, "R9");
    conv(1, 1, 10'h001, "R9");
    rd(1, 'h30, "R9");
    conv(1, 2, 10'h002, "R9");
    rd(1, 'h30, "R9");
    rd(1, 'h18, "R9");
    rd(1, 'h30, "R9");
    // R11 same-cycle result and read of the channel
    conv(0, 2, 10'h0AA, "R11");
    tick(1, 0, A(0, 'h18), '0, 2'b01, 6'd2, 20'h00033, "R11");
    rd(0, 'h18, "R11");
    rd(0, 'h30, "R11");
    // random traffic
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      bit en = ($urandom % 3) != 0;
      bit w = ($urandom % 4) == 0;
      int u = $urandom % 2;
      int o = ($urandom % 14) * 4;
      logic [1:0] dn = {($urandom % 4) == 0, ($urandom % 4) == 0};
      tick(en, w, A(u, o), $urandom, dn, 6'($urandom), 20'($urandom), "R2");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule